// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time as six packed BCD bytes: seconds, minutes, hours (24-hour form), day of month, month (01 to 12) and a two-digit year (00 to 99, years counted from 2000). A tick input pulses at 32768 Hz. While the run control is high, a prescaler turns those ticks into one step per second, and the step ripples through the fields as decimal carries. Day of month wraps at the length of the current month, and February has 29 days in years divisible by four.

Software or a neighbouring block sets the time through a load strobe that writes all six fields in one cycle and restarts the prescaler. One-cycle event pulses mark each second step and each roll-over of seconds, minutes and hours. A further pulse fires on the second step that lands on a time equal, field for field, to the six alarm inputs. No alarm field can be left out of the comparison.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00 on day 01, month 01, year 00 (all packed BCD), and every event pulse and the alarm pulse are low.
- R2: A load strobe writes all six fields in one cycle, and the loaded values appear on the outputs after the next clock edge. A digit above 9 is kept exactly as written. The load also clears the prescaler, so a full PRESCALE ticks must follow before the next second step.
- R3: While run is low the fields and the prescaler hold their values whatever the tick input does, and no event or alarm pulse is raised.
- R4: While run is high the seconds field advances once for every PRESCALE cycles in which the tick input is high, with a decimal carry (09 becomes 10).
- R5: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the day.
- R6: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 29 (leap year, year divisible by 4) or day 28 in month 02. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: The second pulse is high for exactly one cycle after each second step, in the cycle the new value is first visible. The minute pulse marks a seconds wrap, the hour pulse a minutes wrap and the day pulse an hours wrap, each in that same cycle.
- R8: The alarm pulse is high for one cycle, together with the second pulse, when a second step produces a time whose six fields all equal the alarm inputs. A mismatch in any single field, including the year, suppresses it, and a load never raises it.
- R9: When a load and a second step fall in the same cycle, the load wins: the loaded values appear and no event pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle tick at 32768 Hz |
| run | input | 1 | Counting enabled when high |
| load | input | 1 | Writes all six load values |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hours to load, BCD |
| ld_day | input | 8 | Day of month to load, BCD |
| ld_mon | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| al_sec | input | 8 | Alarm seconds, BCD |
| al_min | input | 8 | Alarm minutes, BCD |
| al_hour | input | 8 | Alarm hours, BCD |
| al_day | input | 8 | Alarm day, BCD |
| al_mon | input | 8 | Alarm month, BCD |
| al_year | input | 8 | Alarm year, BCD |
| tm_sec | output | 8 | Current seconds |
| tm_min | output | 8 | Current minutes |
| tm_hour | output | 8 | Current hours |
| tm_day | output | 8 | Current day of month |
| tm_mon | output | 8 | Current month |
| tm_year | output | 8 | Current year |
| ev_sec | output | 1 | Second step pulse |
| ev_min | output | 1 | Seconds wrap pulse |
| ev_hour | output | 1 | Minutes wrap pulse |
| ev_day | output | 1 | Hours wrap pulse |
| alarm_hit | output | 1 | Alarm match pulse |

## Verification
Start times are loaded just before each boundary: a plain 09-to-10 digit carry, a midnight that lands on a leap-year February 29, a non-leap February 28, the end of a 30-day month, and the end of year 99. Together these separate a correct month-length table and leap rule from one that is off by a day, and they show whether each carry stops at the right field. The alarm is approached so that it is checked one second early, on the exact second and one second late, and again with only the year differing, which tells exact six-field matching apart from a partial compare. Stopped stretches, a load made partway through a prescaler count, and a load that collides with a step show whether the prescaler holds, restarts or yields as required.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

   typedef logic [7:0] bcd8_t;

   localparam int NUM_FIELDS = 6;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;

   // one decimal increment; an out-of-range low digit simply carries
   function automatic bcd8_t bcd_next(bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four, decided on the two BCD digits directly
   function automatic logic leap_year(bcd8_t y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic bcd8_t month_len(bcd8_t mon, bcd8_t yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd8_t field_first(int idx);
      return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd8_t field_last(int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_MON:        return 8'h12;
         F_YEAR:       return 8'h99;
         default:      return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_prescaler.sv
module bcd_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic sec_step
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   initial assert (DIV >= 2) else $error("bcd_prescaler: DIV must be at least 2");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (run && tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign sec_step = run & tick & (cnt == LAST);

   assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/bcd_field.sv
module bcd_field
   import bcd_cal_pkg::*;
#(
   parameter bcd8_t FIRST = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  bcd8_t load_val,
   input  logic  step,
   input  bcd8_t wrap_at,
   output bcd8_t val,
   output logic  carry
);
   assign carry = step & (val == wrap_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val <= FIRST;
      else if (load)  val <= load_val;
      else if (step)  val <= carry ? FIRST : bcd_next(val);
   end

   assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (val != $past(val)));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcd_cal_pkg::*;
#(
   parameter int PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_32k,
   input  logic       run,
   input  logic       load,
   input  logic [7:0] ld_sec,
   input  logic [7:0] ld_min,
   input  logic [7:0] ld_hour,
   input  logic [7:0] ld_day,
   input  logic [7:0] ld_mon,
   input  logic [7:0] ld_year,
   input  logic [7:0] al_sec,
   input  logic [7:0] al_min,
   input  logic [7:0] al_hour,
   input  logic [7:0] al_day,
   input  logic [7:0] al_mon,
   input  logic [7:0] al_year,
   output logic [7:0] tm_sec,
   output logic [7:0] tm_min,
   output logic [7:0] tm_hour,
   output logic [7:0] tm_day,
   output logic [7:0] tm_mon,
   output logic [7:0] tm_year,
   output logic       ev_sec,
   output logic       ev_min,
   output logic       ev_hour,
   output logic       ev_day,
   output logic       alarm_hit
);
   localparam int NF = NUM_FIELDS;

   logic          raw_step, sec_step;
   bcd8_t         fld   [NF];
   bcd8_t         ld_v  [NF];
   logic [NF-1:0] carry;
   logic [NF-1:0] step;
   logic [3:0]    ev_q;

   assign ld_v[F_SEC]  = ld_sec;
   assign ld_v[F_MIN]  = ld_min;
   assign ld_v[F_HOUR] = ld_hour;
   assign ld_v[F_DAY]  = ld_day;
   assign ld_v[F_MON]  = ld_mon;
   assign ld_v[F_YEAR] = ld_year;

   bcd_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(load), .run(run), .tick(tick_32k),
      .sec_step(raw_step)
   );

   assign sec_step = raw_step & ~load;
   assign step     = {carry[NF-2:0], sec_step};

   for (genvar i = 0; i < NF; i++) begin : g_fld
      bcd8_t wrap_i;
      if (i == F_DAY) begin : g_month_len
         assign wrap_i = month_len(fld[F_MON], fld[F_YEAR]);
      end else begin : g_fixed
         assign wrap_i = field_last(i);
      end
      bcd_field #(.FIRST(field_first(i))) u_field (
         .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_v[i]),
         .step(step[i]), .wrap_at(wrap_i), .val(fld[i]), .carry(carry[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= {carry[F_HOUR], carry[F_MIN], carry[F_SEC], sec_step};
   end

   assign tm_sec  = fld[F_SEC];
   assign tm_min  = fld[F_MIN];
   assign tm_hour = fld[F_HOUR];
   assign tm_day  = fld[F_DAY];
   assign tm_mon  = fld[F_MON];
   assign tm_year = fld[F_YEAR];
   assign ev_sec  = ev_q[0];
   assign ev_min  = ev_q[1];
   assign ev_hour = ev_q[2];
   assign ev_day  = ev_q[3];

   // the match is only meaningful in the cycle a step has just landed
   assign alarm_hit = ev_q[0]
                    & (fld[F_SEC]  == al_sec)  & (fld[F_MIN] == al_min)
                    & (fld[F_HOUR] == al_hour) & (fld[F_DAY] == al_day)
                    & (fld[F_MON]  == al_mon)  & (fld[F_YEAR] == al_year);

   assert_load_all_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tm_sec == $past(ld_sec) && tm_min == $past(ld_min) &&
                tm_hour == $past(ld_hour) && tm_day == $past(ld_day) &&
                tm_mon == $past(ld_mon) && tm_year == $past(ld_year)));
   assert_frozen_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> ($stable({tm_sec, tm_min, tm_hour, tm_day, tm_mon, tm_year})
                           && !ev_sec));
   assert_step_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sec |-> ($past(run) && $past(tick_32k) && !$past(load)));
   assert_day_after_midnight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_day |-> (tm_hour == 8'h00 && tm_min == 8'h00 && tm_sec == 8'h00));
   assert_year_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      carry[F_YEAR] |=> (tm_year == 8'h00 && tm_mon == 8'h01 && tm_day == 8'h01));
   assert_min_needs_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_min |-> (ev_sec && tm_sec == 8'h00));
   assert_alarm_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> !alarm_hit);
   assert_load_beats_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !(ev_sec || ev_min || ev_hour || ev_day));
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
   localparam int PS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_32k = 1'b0, run = 1'b0, load = 1'b0;
   logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_day = '0, ld_mon = '0, ld_year = '0;
   logic [7:0] al_sec = 8'h77, al_min = '0, al_hour = '0, al_day = '0, al_mon = '0, al_year = '0;
   logic [7:0] tm_sec, tm_min, tm_hour, tm_day, tm_mon, tm_year;
   logic ev_sec, ev_min, ev_hour, ev_day, alarm_hit;

   always #4 clk = ~clk;

   bcd_calendar #(.PRESCALE(PS)) u_bcd_calendar (.*);

   int n_cmp = 0, n_bad = 0;
   logic [52:0] exp_q [$];
   int ms, mm, mh, md, mmo, my;

   function automatic logic [7:0] b2d(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction
   function automatic int d2b(logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction
   function automatic int dim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [52:0] dut_vec();
      return {alarm_hit, ev_day, ev_hour, ev_min, ev_sec,
              tm_year, tm_mon, tm_day, tm_hour, tm_min, tm_sec};
   endfunction

   task automatic check(string req, logic [52:0] act, logic [52:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // advance the reference by one second and queue the expected result
   task automatic expect_step(string req);
      logic em = 0, eh = 0, ed = 0, al;
      logic [47:0] t;
      ms++;
      if (ms == 60) begin
         ms = 0; em = 1; mm++;
         if (mm == 60) begin
            mm = 0; eh = 1; mh++;
            if (mh == 24) begin
               mh = 0; ed = 1; md++;
               if (md > dim(mmo, my)) begin
                  md = 1; mmo++;
                  if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
               end
            end
         end
      end
      t  = {b2d(my), b2d(mmo), b2d(md), b2d(mh), b2d(mm), b2d(ms)};
      al = (t == {al_year, al_mon, al_day, al_hour, al_min, al_sec});
      exp_q.push_back({al, ed, eh, em, 1'b1, t});
      $display("  queued step for %s", req);
   endtask

   task automatic ticks(int n);
      @(negedge clk); tick_32k = 1'b1;
      repeat (n) @(negedge clk);
      tick_32k = 1'b0;
   endtask

   task automatic drained(string req);
      @(negedge clk);
      check(req, 53'(exp_q.size()), 53'd0);
   endtask

   task automatic do_load(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                          logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                          logic with_tick, string req);
      @(negedge clk);
      ld_sec = s; ld_min = mi; ld_hour = h; ld_day = d; ld_mon = mo; ld_year = y;
      load = 1'b1; tick_32k = with_tick;
      @(negedge clk);
      load = 1'b0; tick_32k = 1'b0;
      check(req, dut_vec(), {5'b0, y, mo, d, h, mi, s});
      ms = d2b(s); mm = d2b(mi); mh = d2b(h); md = d2b(d); mmo = d2b(mo); my = d2b(y);
   endtask

   // monitor: every pulse must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && (ev_sec || ev_min || ev_hour || ev_day || alarm_hit)) begin
         if (exp_q.size() > 0) check("R7 step result", dut_vec(), exp_q.pop_front());
         else check("R3/R9 unexpected pulse", dut_vec(), 53'd0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", dut_vec(), {5'b0, 8'h00, 8'h01, 8'h01, 24'h0});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", dut_vec(), {5'b0, 8'h00, 8'h01, 8'h01, 24'h0});
      run = 1'b1;

      // R4 plain digit carry
      do_load(8'h09, 8'h00, 8'h10, 8'h05, 8'h03, 8'h22, 1'b0, "R2 load");
      expect_step("R4 09->10"); ticks(PS); drained("R4");
      // R5/R6 leap February
      do_load(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 1'b0, "R2 load");
      expect_step("R4"); ticks(PS);
      expect_step("R6 leap Feb 29"); ticks(PS); drained("R6");
      // R6 non-leap February
      do_load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 1'b0, "R2 load");
      expect_step("R6 Feb 28 -> Mar 1"); ticks(PS); drained("R6");
      // R6 30-day month
      do_load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h21, 1'b0, "R2 load");
      expect_step("R6 Apr 30 -> May 1"); ticks(PS); drained("R6");
      // R6 year wrap
      do_load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 1'b0, "R2 load");
      expect_step("R6 99 -> 00"); ticks(PS); drained("R6");
      // R5 minute and hour carries only
      do_load(8'h59, 8'h59, 8'h07, 8'h15, 8'h07, 8'h30, 1'b0, "R2 load");
      expect_step("R5 hour carry"); ticks(PS); drained("R5");

      // R8 alarm early, exact, late
      al_sec = 8'h05; al_min = 8'h30; al_hour = 8'h12; al_day = 8'h15; al_mon = 8'h06; al_year = 8'h24;
      do_load(8'h03, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24, 1'b0, "R2 load");
      expect_step("R8 early"); ticks(PS);
      expect_step("R8 exact"); ticks(PS);
      expect_step("R8 late"); ticks(PS); drained("R8");
      // R8 year alone differs
      al_year = 8'h25;
      do_load(8'h04, 8'h30, 8'h12, 8'h15, 8'h06, 8'h24, 1'b0, "R8 no pulse on load");
      expect_step("R8 year mismatch"); ticks(PS); drained("R8");
      al_sec = 8'h77;

      // R3 stopped mid-count
      do_load(8'h20, 8'h11, 8'h09, 8'h10, 8'h10, 8'h10, 1'b0, "R2 load");
      ticks(2);
      @(negedge clk); run = 1'b0;
      ticks(10); drained("R3");
      check("R3 frozen fields", dut_vec(), {5'b0, 8'h10, 8'h10, 8'h10, 8'h09, 8'h11, 8'h20});
      @(negedge clk); run = 1'b1;
      expect_step("R3 prescaler held"); ticks(2); drained("R3");

      // R2 load clears the prescaler
      ticks(3);
      do_load(8'h40, 8'h11, 8'h09, 8'h10, 8'h10, 8'h10, 1'b0, "R2 load");
      ticks(PS - 1); drained("R2 no early step");
      check("R2 unchanged", dut_vec(), {5'b0, 8'h10, 8'h10, 8'h10, 8'h09, 8'h11, 8'h40});
      expect_step("R2 full count"); ticks(1); drained("R2");

      // R9 load collides with step
      ticks(PS - 1);
      do_load(8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R9 load wins");
      drained("R9");
      expect_step("R9 after"); ticks(PS); drained("R9");

      // R2 invalid digits kept
      @(negedge clk); run = 1'b0;
      do_load(8'h3F, 8'h7A, 8'h2C, 8'h0B, 8'h1E, 8'hAA, 1'b0, "R2 invalid BCD kept");
      ticks(PS); drained("R2");
      check("R2 invalid BCD held", dut_vec(), {5'b0, 8'hAA, 8'h1E, 8'h0B, 8'h2C, 8'h7A, 8'h3F});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule